// File: doc/BRIEF.md
# DPLL Operating State Controller

This block is the supervisory state machine that sits beside the loop filter of a digital phase-locked loop. It watches a reference-valid flag and the magnitude of the phase error, and from them decides which operating condition the loop is in. These conditions are: acquiring (unlocked), locked, locked with a settled holdover average, holdover, and free-run. While the loop is locked it keeps an exponential moving average of the loop's frequency control word. When the reference disappears it steers the oscillator from that stored average. When holdover outlasts a programmable number of seconds it falls back to a fixed nominal word.

All lock and averaging decisions are qualified by an update strobe that marks each new loop-filter result. The holdover limit is counted with a one-pulse-per-second tick. Every state change produces a single-cycle interrupt pulse, so software or a neighbouring block can follow the state sequence without polling.

States and transitions: reset enters HOLDOVER. HOLDOVER goes to UNLOCKED when the reference is valid, or to FREE_RUN when the timer expires. FREE_RUN goes to UNLOCKED when the reference is valid. UNLOCKED goes to LOCKED on the lock count, or to HOLDOVER when the reference is lost. LOCKED goes to LOCKED_ACQ when the averaging count completes, to UNLOCKED on a phase slip, or to HOLDOVER when the reference is lost. LOCKED_ACQ goes to UNLOCKED on a phase slip, or to HOLDOVER when the reference is lost.

Top module: `dpll_state_ctrl`

## Requirements
- R1: `state_code` encodes unlocked as 0, free-run as 1, locked as 2, locked-with-average-acquired as 3 and holdover as 4. The value 4'hF (-1, unknown) is reserved and never driven, and no other value appears.
- R2: While reset is asserted and directly after it, the state is holdover (4), `nco_word` equals the nominal word and `chg_irq` is low.
- R3: In unlocked, locked or locked-with-average-acquired, a low `ref_ok` moves the state to holdover on the next clock edge.
- R4: In unlocked with the reference valid, the state becomes locked on the edge of the 64th consecutive strobe whose phase error is strictly below `lock_thr`. A strobe with error equal to or above the threshold restarts the count.
- R5: In locked or locked-with-average-acquired, a strobe whose error exceeds twice `lock_thr` returns the state to unlocked. An error exactly equal to twice the threshold has no effect on the state.
- R6: Locked moves to locked-with-average-acquired on the 1024th averaged update since entering locked.
- R7: Each strobe that is accepted in either locked state (reference valid, no slip) updates avg to avg + floor((loop_word - avg) / 256), with avg starting at the nominal word after reset. In holdover `nco_word` equals that average and does not change.
- R8: In holdover with no reference, once the number of ticks counted since entering holdover reaches `ho_limit_s`, the next edge moves the state to free-run. In free-run `nco_word` is the nominal word.
- R9: A valid reference in holdover or free-run moves the state to unlocked on the next edge, and takes priority over holdover expiry.
- R10: `chg_irq` is high for exactly the one cycle after each edge on which the state changed, and low otherwise.
- R11: In unlocked, locked and locked-with-average-acquired, `nco_word` follows `loop_word` combinationally.
- R12: Free-run with no valid reference stays in free-run regardless of strobes and ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_ok | input | 1 | Selected reference is valid |
| upd_stb | input | 1 | New loop-filter result available |
| phase_err_mag | input | PW | Phase-error magnitude for this update |
| loop_word | input | FW | Frequency word produced by the loop filter |
| lock_thr | input | PW | Lock threshold on the phase-error magnitude |
| ho_limit_s | input | HW | Holdover duration limit in seconds |
| tick_1hz | input | 1 | One-cycle pulse each second |
| state_code | output | 4 | Operating state code |
| nco_word | output | FW | Frequency word for the oscillator |
| chg_irq | output | 1 | One-cycle pulse on each state change |

## Verification
The assertions check the following on every cycle: the legal code range, that the interrupt pulse coincides with every change of the state code, and that the oscillator word stays frozen through holdover and is the nominal word in free-run. They also check that a lost reference always leads to holdover, and that locked and free-run can each be entered only from their single legal predecessor. Some behaviours depend on long histories, and only the bench's scenarios can show them: the exact 64-strobe lock count and its restart, the equal-to-twice-threshold boundary, the 1024th-update promotion, the numerical value of the averaged word, and the tick count at which holdover expires.

// File: rtl/dpll_state_pkg.sv
package dpll_state_pkg;
    typedef enum logic [3:0] {
        ST_UNLK = 4'd0,
        ST_FREE = 4'd1,
        ST_LOCK = 4'd2,
        ST_LACQ = 4'd3,
        ST_HOLD = 4'd4,
        ST_UNKN = 4'hF
    } op_state_t;
endpackage

// File: rtl/dpll_lock_det.sv
module dpll_lock_det #(
    parameter int PW       = 16,
    parameter int LOCK_CNT = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          upd,
    input  logic [PW-1:0] err,
    input  logic [PW-1:0] thr,
    output logic          lock_hit,
    output logic          slip
);
    localparam int CW = $clog2(LOCK_CNT + 1);
    localparam logic [CW-1:0] LAST = CW'(LOCK_CNT - 1);

    logic [CW-1:0] run_cnt;
    logic          below;

    always_comb begin
        below    = (err < thr);
        slip     = upd && ({1'b0, err} > {thr, 1'b0});
        lock_hit = upd && below && (run_cnt == LAST);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            run_cnt <= '0;
        end else if (upd) begin
            if (!below)
                run_cnt <= '0;
            else if (run_cnt != LAST)
                run_cnt <= run_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/dpll_freq_avg.sv
module dpll_freq_avg #(
    parameter int          FW        = 32,
    parameter int          AVG_SHIFT = 8,
    parameter int          ACQ_CNT   = 1024,
    parameter logic [FW-1:0] NOM_WORD = 32'h4000_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          upd,
    input  logic [FW-1:0] loop_word,
    output logic [FW-1:0] avg_word,
    output logic          acq_hit
);
    localparam int AW = $clog2(ACQ_CNT + 1);
    localparam logic [AW-1:0] LAST = AW'(ACQ_CNT - 1);

    logic [AW-1:0] acq_cnt;
    logic [FW-1:0] avg_nxt;

    generate
        if (AVG_SHIFT == 0) begin : g_direct
            always_comb avg_nxt = loop_word;
        end else begin : g_ema
            logic signed [FW:0] diff;
            logic signed [FW:0] step;
            always_comb begin
                diff    = $signed({1'b0, loop_word}) - $signed({1'b0, avg_word});
                step    = diff >>> AVG_SHIFT;
                avg_nxt = avg_word + step[FW-1:0];
            end
        end
    endgenerate

    assign acq_hit = upd && (acq_cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            avg_word <= NOM_WORD;
        end else if (upd) begin
            avg_word <= avg_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acq_cnt <= '0;
        end else if (upd && acq_cnt != LAST) begin
            acq_cnt <= acq_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/dpll_ho_timer.sv
module dpll_ho_timer #(
    parameter int HW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic [HW-1:0] limit,
    output logic          expired
);
    logic [HW-1:0] sec_cnt;

    assign expired = (sec_cnt >= limit);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            sec_cnt <= '0;
        end else if (tick && sec_cnt != {HW{1'b1}}) begin
            sec_cnt <= sec_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/dpll_state_ctrl.sv
module dpll_state_ctrl
    import dpll_state_pkg::*;
#(
    parameter int            FW        = 32,
    parameter int            PW        = 16,
    parameter int            HW        = 17,
    parameter int            LOCK_CNT  = 64,
    parameter int            ACQ_CNT   = 1024,
    parameter int            AVG_SHIFT = 8,
    parameter logic [FW-1:0] NOM_WORD  = 32'h4000_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_ok,
    input  logic          upd_stb,
    input  logic [PW-1:0] phase_err_mag,
    input  logic [FW-1:0] loop_word,
    input  logic [PW-1:0] lock_thr,
    input  logic [HW-1:0] ho_limit_s,
    input  logic          tick_1hz,
    output logic [3:0]    state_code,
    output logic [FW-1:0] nco_word,
    output logic          chg_irq
);
    op_state_t     state, nxt;
    logic          lock_hit, slip, acq_hit, ho_expired;
    logic          in_lock, avg_upd;
    logic [FW-1:0] avg_word;

    assign in_lock = (state == ST_LOCK) || (state == ST_LACQ);
    assign avg_upd = in_lock && ref_ok && upd_stb && !slip;

    dpll_lock_det #(.PW(PW), .LOCK_CNT(LOCK_CNT)) u_lock (
        .clk(clk), .rst_n(rst_n), .clr(state != ST_UNLK), .upd(upd_stb),
        .err(phase_err_mag), .thr(lock_thr), .lock_hit(lock_hit), .slip(slip)
    );

    dpll_freq_avg #(.FW(FW), .AVG_SHIFT(AVG_SHIFT), .ACQ_CNT(ACQ_CNT),
                    .NOM_WORD(NOM_WORD)) u_avg (
        .clk(clk), .rst_n(rst_n), .clr(!in_lock), .upd(avg_upd),
        .loop_word(loop_word), .avg_word(avg_word), .acq_hit(acq_hit)
    );

    dpll_ho_timer #(.HW(HW)) u_ho (
        .clk(clk), .rst_n(rst_n), .run(state == ST_HOLD), .tick(tick_1hz),
        .limit(ho_limit_s), .expired(ho_expired)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_HOLD: begin
                if (ref_ok)          nxt = ST_UNLK;
                else if (ho_expired) nxt = ST_FREE;
            end
            ST_FREE: begin
                if (ref_ok)          nxt = ST_UNLK;
            end
            ST_UNLK: begin
                if (!ref_ok)         nxt = ST_HOLD;
                else if (lock_hit)   nxt = ST_LOCK;
            end
            ST_LOCK: begin
                if (!ref_ok)         nxt = ST_HOLD;
                else if (slip)       nxt = ST_UNLK;
                else if (acq_hit)    nxt = ST_LACQ;
            end
            ST_LACQ: begin
                if (!ref_ok)         nxt = ST_HOLD;
                else if (slip)       nxt = ST_UNLK;
            end
            default:                 nxt = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_HOLD;
            chg_irq <= 1'b0;
        end else begin
            state   <= nxt;
            chg_irq <= (nxt != state);
        end
    end

    always_comb begin
        state_code = state;
        unique case (state)
            ST_HOLD: nco_word = avg_word;
            ST_FREE: nco_word = NOM_WORD;
            default: nco_word = loop_word;
        endcase
    end
endmodule

// File: rtl/dpll_state_chk.sv
module dpll_state_chk #(
    parameter int            FW       = 32,
    parameter logic [FW-1:0] NOM_WORD = 32'h4000_0000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ref_ok,
    input logic [3:0]    state_code,
    input logic [FW-1:0] nco_word,
    input logic          chg_irq
);
    // R1
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_code <= 4'd4);

    // R10
    irq_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(state_code) |-> chg_irq);

    // R10
    irq_only_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg_irq |-> (state_code != $past(state_code)));

    // R3
    loss_to_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_ok && (state_code == 4'd0 || state_code == 4'd2 || state_code == 4'd3))
        |=> (state_code == 4'd4));

    // R7
    hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 4'd4) |=> (state_code != 4'd4 || $stable(nco_word)));

    // R8
    free_nominal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 4'd1) |-> (nco_word == NOM_WORD));

    // R8
    free_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 4'd1 && $past(state_code) != 4'd1) |-> ($past(state_code) == 4'd4));

    // R4
    lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 4'd2 && $past(state_code) != 4'd2) |-> ($past(state_code) == 4'd0));
endmodule

bind dpll_state_ctrl dpll_state_chk #(.FW(FW), .NOM_WORD(NOM_WORD)) u_chk (
    .clk(clk), .rst_n(rst_n), .ref_ok(ref_ok), .state_code(state_code),
    .nco_word(nco_word), .chg_irq(chg_irq)
);

// File: tb/sim_dpll_state_ctrl.sv
`timescale 1ns/1ps
module sim_dpll_state_ctrl;
    localparam logic [31:0] NOM = 32'h4000_0000;
    localparam int THR = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_ok = 1'b0, upd = 1'b0, tick = 1'b0;
    logic [15:0] err = '0, thr = 16'(THR);
    logic [31:0] lw = NOM;
    logic [16:0] lim = 17'd3;
    logic [3:0]  state_code;
    logic [31:0] nco_word;
    logic        chg_irq;

    int errors = 0, checks = 0, cycles = 0;
    string cur_req = "R2";

    always #2.5 clk = ~clk;

    dpll_state_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ref_ok(ref_ok), .upd_stb(upd),
        .phase_err_mag(err), .loop_word(lw), .lock_thr(thr),
        .ho_limit_s(lim), .tick_1hz(tick), .state_code(state_code),
        .nco_word(nco_word), .chg_irq(chg_irq)
    );

    // behavioural reference model
    int     ms = 4, mgood = 0, macq = 0, mho = 0;
    longint mavg = longint'(NOM);
    bit     mirq = 0;

    always @(posedge clk) begin
        int nx;
        bit slipm, acc;
        if (!rst_n) begin
            ms = 4; mgood = 0; macq = 0; mho = 0; mavg = longint'(NOM); mirq = 0;
        end else begin
            slipm = upd && (int'(err) > 2 * int'(thr));
            acc   = (ms == 2 || ms == 3) && ref_ok && upd && !slipm;
            nx = ms;
            case (ms)
                4: if (ref_ok) nx = 0; else if (mho >= int'(lim)) nx = 1;
                1: if (ref_ok) nx = 0;
                0: if (!ref_ok) nx = 4;
                   else if (upd && int'(err) < int'(thr) && mgood == 63) nx = 2;
                default: if (!ref_ok) nx = 4;
                   else if (slipm) nx = 0;
                   else if (ms == 2 && acc && macq == 1023) nx = 3;
            endcase
            if (ms != 0) mgood = 0;
            else if (upd) mgood = (int'(err) < int'(thr)) ? ((mgood < 63) ? mgood + 1 : mgood) : 0;
            if (!(ms == 2 || ms == 3)) macq = 0;
            else if (acc && macq < 1023) macq = macq + 1;
            if (acc) mavg = mavg + ((longint'(lw) - mavg) >>> 8);
            if (ms != 4) mho = 0;
            else if (tick && mho < 131071) mho = mho + 1;
            mirq = (nx != ms);
            ms = nx;
        end
    end

    function automatic logic [31:0] model_nco();
        if (ms == 4) return mavg[31:0];
        if (ms == 1) return NOM;
        return lw;
    endfunction

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", r, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk(cur_req, 32'(state_code), 32'(ms));
            chk("R10", 32'(chg_irq), 32'(mirq));
            chk(cur_req, nco_word, model_nco());
        end
    end

    task automatic cyc(input bit u, input int e, input logic [31:0] w, input bit t);
        upd = u; err = 16'(e); lw = w; tick = t;
        @(posedge clk); #1;
        upd = 0; tick = 0;
    endtask

    task automatic lock_up(input logic [31:0] w);
        for (int i = 0; i < 64; i++) cyc(1, 10, w, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R2", 32'(state_code), 32'd4);
        chk("R2", nco_word, NOM);
        chk("R2", 32'(chg_irq), 32'd0);
        rst_n = 1;
        cyc(0, 0, NOM, 0);
        chk("R2", 32'(state_code), 32'd4);

        // R9: reference appears in holdover
        cur_req = "R9";
        ref_ok = 1;
        cyc(0, 0, NOM, 0);
        chk("R9", 32'(state_code), 32'd0);
        chk("R10", 32'(chg_irq), 32'd1);
        cyc(0, 0, NOM, 0);
        chk("R10", 32'(chg_irq), 32'd0);

        // R4: count restart then lock on 64th
        cur_req = "R4";
        for (int i = 0; i < 63; i++) cyc(1, 10, 32'h4000_1000, 0);
        cyc(1, THR, 32'h4000_1000, 0);
        chk("R4", 32'(state_code), 32'd0);
        for (int i = 0; i < 63; i++) cyc(1, 99, 32'h4000_1000, 0);
        chk("R4", 32'(state_code), 32'd0);
        cyc(1, 99, 32'h4000_1000, 0);
        chk("R4", 32'(state_code), 32'd2);
        chk("R11", nco_word, 32'h4000_1000);

        // R5: boundary and slip
        cur_req = "R5";
        cyc(1, 2 * THR, 32'h4000_1000, 0);
        chk("R5", 32'(state_code), 32'd2);
        cyc(1, 2 * THR + 1, 32'h4000_1000, 0);
        chk("R5", 32'(state_code), 32'd0);
        lock_up(32'h4000_1000);
        chk("R4", 32'(state_code), 32'd2);

        // R6: 1024 averaged updates
        cur_req = "R6";
        for (int i = 0; i < 1023; i++)
            cyc(1, 20, 32'h4000_2000 + ((i % 2) ? 32'h300 : 32'h0) + 32'(i), 0);
        chk("R6", 32'(state_code), 32'd2);
        cyc(1, 20, 32'h4000_2400, 0);
        chk("R6", 32'(state_code), 32'd3);
        chk("R11", nco_word, 32'h4000_2400);
        cur_req = "R11";
        cyc(0, 0, 32'h4000_5555, 0);
        chk("R11", nco_word, 32'h4000_5555);

        // R3 / R7: drop reference
        cur_req = "R7";
        ref_ok = 0;
        cyc(0, 0, 32'h1234_5678, 0);
        chk("R3", 32'(state_code), 32'd4);
        chk("R7", nco_word, mavg[31:0]);
        cyc(1, 5, 32'h7777_0000, 0);
        chk("R7", nco_word, mavg[31:0]);

        // R8: timed fall-back
        cur_req = "R8";
        cyc(0, 0, NOM, 1);
        cyc(0, 0, NOM, 1);
        cyc(0, 0, NOM, 1);
        chk("R8", 32'(state_code), 32'd4);
        cyc(0, 0, 32'h0BAD_0000, 0);
        chk("R8", 32'(state_code), 32'd1);
        chk("R8", nco_word, NOM);

        // R12: free-run holds
        cur_req = "R12";
        for (int i = 0; i < 20; i++) cyc(i % 2, 3, 32'h5000_0000, i % 3 == 0);
        chk("R12", 32'(state_code), 32'd1);
        ref_ok = 1;
        cyc(0, 0, 32'h4000_0100, 0);
        chk("R9", 32'(state_code), 32'd0);

        // R3 from unlocked, then R9 priority over expiry
        cur_req = "R3";
        ref_ok = 0;
        cyc(0, 0, NOM, 0);
        chk("R3", 32'(state_code), 32'd4);
        cur_req = "R9";
        lim = 17'd0;
        ref_ok = 1;
        cyc(0, 0, NOM, 0);
        chk("R9", 32'(state_code), 32'd0);
        lock_up(32'h4000_0800);
        cur_req = "R3";
        ref_ok = 0;
        cyc(0, 0, NOM, 0);
        chk("R3", 32'(state_code), 32'd4);
        cur_req = "R8";
        cyc(0, 0, NOM, 0);
        chk("R8", 32'(state_code), 32'd1);
        chk("R1", 32'(state_code), 32'd1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule